// File: doc/BRIEF.md
# Uniform-Grid Interpolating Lookup Translator

This block maps a 12-bit converter code to a signed output value. It does this with a sparse table of breakpoints placed at equal steps along the code axis, and it draws a straight line between each pair of neighbouring breakpoints. Because the step is a power of two, the top bits of the code pick the segment directly, with no search. The low bits give the position inside that segment. A typical use is turning a requested physical quantity into a converter setting fast enough to change the setpoint while an output event is still running.

Software loads the 2^K+1 breakpoints through a simple write port before translation starts. Codes then arrive on a valid/ready input, one per cycle. Each code produces one result on a valid output a fixed two cycles later. The table has one more entry than there are segments, so the top segment has its own upper end point.

Top module: `grid_interp_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0. `in_ready` is 0 while in reset and 1 from the first clock edge after reset is released.
- R2: The segment index is `in_code[11:12-K]` and the fraction is `in_code[11-K:0]` (with K=4: bits 11:8 and 7:0). A code with fraction 0 returns table entry p[index] exactly.
- R3: For other codes the result is p[i] + floor(((p[i+1]-p[i]) * frac) / 2^(12-K)), computed in signed arithmetic. The value always lies between p[i] and p[i+1].
- R4: A code accepted on a clock edge (`in_valid` and `in_ready` both high) yields `out_valid`=1 with its result exactly two edges later. Cycles with no accepted code yield `out_valid`=0 two edges later.
- R5: Codes presented on consecutive cycles are all accepted, and their results come out on consecutive cycles in the same order.
- R6: Writing with `tbl_wr_en`=1 stores `tbl_wr_data` at entry `tbl_wr_addr` (0 to 2^K). Any later translation that uses that entry sees the new value.
- R7: A code accepted on the same edge as a table write uses the table as it was before that write. A code accepted on a later edge uses the written value.
- R8: Descending segments and negative breakpoint values are interpolated correctly. This includes a full-scale swing from +30000 to -30000 within one segment.
- R9: Codes in the top segment (index 2^K-1) interpolate towards entry p[2^K]. Code 4095 returns p[15] + floor((p[16]-p[15])*255/256).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input code present |
| in_ready | output | 1 | Block can accept a code this cycle |
| in_code | input | 12 | Code to translate |
| out_valid | output | 1 | Result present |
| out_value | output | 16 | Signed interpolated result |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | 5 | Breakpoint index written |
| tbl_wr_data | input | 16 | Signed breakpoint value |

## Verification
Each result is due exactly two rising edges after its code is accepted. The first edge registers both table reads and the fraction; the second registers the multiply-add. The bench drives inputs on falling edges. It checks that `out_valid` is still low at the first falling edge after acceptance, then compares the value at the second. A write is visible to a code accepted one edge after the write, so the collision test puts a write and a code on the same edge and expects the old entry. It then expects the new entry for the code that follows on the next edge.

// File: rtl/grid_interp_pkg.sv
package grid_interp_pkg;
  localparam int CODE_BITS = 12;
  localparam int SEG_BITS  = 4;
  localparam int VALUE_BITS = 16;

  function automatic int point_count(input int seg_bits);
    return (1 << seg_bits) + 1;
  endfunction
endpackage

// File: rtl/grid_index_split.sv
module grid_index_split #(
  parameter int CODE_W = 12,
  parameter int K      = 4,
  localparam int FRAC_W = CODE_W - K,
  localparam int ADDR_W = K + 1
) (
  input  logic [CODE_W-1:0]        code,
  output logic [1:0][ADDR_W-1:0]   rd_addr,
  output logic [FRAC_W-1:0]        frac
);
  logic [K-1:0] seg;

  always_comb begin
    seg        = code[CODE_W-1 -: K];
    frac       = code[FRAC_W-1:0];
    rd_addr[0] = {1'b0, seg};
    rd_addr[1] = {1'b0, seg} + {{(ADDR_W-1){1'b0}}, 1'b1};
  end
endmodule

// File: rtl/grid_point_table.sv
module grid_point_table #(
  parameter int VAL_W  = 16,
  parameter int DEPTH  = 17,
  parameter int ADDR_W = 5
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [VAL_W-1:0]         wr_data,
  input  logic                     rd_en,
  input  logic [1:0][ADDR_W-1:0]   rd_addr,
  output logic [1:0][VAL_W-1:0]    rd_data
);
  logic wr_ok;
  assign wr_ok = wr_en && (int'(wr_addr) < DEPTH);

  for (genvar c = 0; c < 2; c++) begin : g_copy
    logic [VAL_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_addr] <= wr_data;
      if (rd_en) rd_data[c] <= mem[rd_addr[c]];
    end
  end

  // R6
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok ##1 (rd_en && rd_addr[0] == $past(wr_addr) && !wr_ok)
      |=> rd_data[0] == $past(wr_data, 2));
endmodule

// File: rtl/grid_lerp_stage.sv
module grid_lerp_stage #(
  parameter int VAL_W  = 16,
  parameter int FRAC_W = 8,
  localparam int PROD_W = VAL_W + FRAC_W + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic [VAL_W-1:0]        p_lo,
  input  logic [VAL_W-1:0]        p_hi,
  input  logic [FRAC_W-1:0]       frac,
  output logic                    out_vld,
  output logic [VAL_W-1:0]        result
);
  logic [VAL_W:0]          diff;
  logic [PROD_W-1:0]       diff_x, frac_x, prod, step, base_x, total;
  logic [PROD_W-VAL_W-1:0] total_hi;
  logic [VAL_W-1:0]        total_lo;

  always_comb begin
    diff     = {p_hi[VAL_W-1], p_hi} - {p_lo[VAL_W-1], p_lo};
    diff_x   = {{(PROD_W-VAL_W-1){diff[VAL_W]}}, diff};
    frac_x   = {{(PROD_W-FRAC_W){1'b0}}, frac};
    prod     = diff_x * frac_x;
    step     = $signed(prod) >>> FRAC_W;
    base_x   = {{(PROD_W-VAL_W){p_lo[VAL_W-1]}}, p_lo};
    total    = base_x + step;
    {total_hi, total_lo} = total;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      result  <= '0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) result <= total_lo;
    end
  end

  // R3
  result_fits_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |-> (total_hi == {(PROD_W-VAL_W){total_lo[VAL_W-1]}}));

  // R2
  grid_exact_chk: assert property (@(posedge clk) disable iff (rst)
    (in_vld && frac == '0) |=> result == $past(p_lo));

  // R3
  between_ends_chk: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> (($signed(result) >= $signed($past(p_lo)) && $signed(result) <= $signed($past(p_hi))) ||
                ($signed(result) <= $signed($past(p_lo)) && $signed(result) >= $signed($past(p_hi)))));
endmodule

// File: rtl/grid_interp_top.sv
module grid_interp_top
  import grid_interp_pkg::*;
#(
  parameter int CODE_W = CODE_BITS,
  parameter int K      = SEG_BITS,
  parameter int VAL_W  = VALUE_BITS,
  localparam int FRAC_W = CODE_W - K,
  localparam int ADDR_W = K + 1,
  localparam int DEPTH  = (1 << K) + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [VAL_W-1:0]  out_value,
  input  logic              tbl_wr_en,
  input  logic [ADDR_W-1:0] tbl_wr_addr,
  input  logic [VAL_W-1:0]  tbl_wr_data
);
  logic                    ready_q, accept, vld_s1;
  logic [1:0][ADDR_W-1:0]  rd_addr;
  logic [1:0][VAL_W-1:0]   rd_data;
  logic [FRAC_W-1:0]       frac_s0, frac_s1;

  assign in_ready = ready_q;
  assign accept   = in_valid && ready_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q <= 1'b0;
      vld_s1  <= 1'b0;
      frac_s1 <= '0;
    end else begin
      ready_q <= 1'b1;
      vld_s1  <= accept;
      if (accept) frac_s1 <= frac_s0;
    end
  end

  grid_index_split #(.CODE_W(CODE_W), .K(K)) split_i (
    .code(in_code), .rd_addr(rd_addr), .frac(frac_s0)
  );

  grid_point_table #(.VAL_W(VAL_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) table_i (
    .clk(clk), .rst(rst),
    .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr), .wr_data(tbl_wr_data),
    .rd_en(accept), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  grid_lerp_stage #(.VAL_W(VAL_W), .FRAC_W(FRAC_W)) lerp_i (
    .clk(clk), .rst(rst), .in_vld(vld_s1),
    .p_lo(rd_data[0]), .p_hi(rd_data[1]), .frac(frac_s1),
    .out_vld(out_valid), .result(out_value)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!out_valid && !in_ready));

  // R4
  latency_two_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> ##1 out_valid);

  // R4
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    (!(in_valid && in_ready)) |=> ##1 !out_valid);
endmodule

// File: tb/grid_interp_top_tb_top.sv
module grid_interp_top_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [11:0] in_code;
  logic        out_valid;
  logic [15:0] out_value;
  logic        tbl_wr_en;
  logic [4:0]  tbl_wr_addr;
  logic [15:0] tbl_wr_data;

  int n_checks = 0;
  int n_fails  = 0;
  int tbl [17];

  always #5 clk = ~clk;

  grid_interp_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .out_valid(out_valid), .out_value(out_value),
    .tbl_wr_en(tbl_wr_en), .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data)
  );

  function automatic int model(input int code);
    int seg, fr, d;
    seg = code >> 8;
    fr  = code & 255;
    d   = tbl[seg+1] - tbl[seg];
    return tbl[seg] + ((d * fr) >>> 8);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic write_pt(input int a, input int v);
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = 5'(a); tbl_wr_data = 16'(v);
    tbl[a] = v;
    @(negedge clk);
    tbl_wr_en = 1'b0;
  endtask

  task automatic translate_one(input string req, input int code);
    int exp;
    exp = model(code);
    @(negedge clk);
    in_valid = 1'b1; in_code = 12'(code);
    @(negedge clk);
    in_valid = 1'b0;
    check(req, int'(out_valid), 0);
    @(negedge clk);
    check(req, int'(out_valid), 1);
    check(req, int'($signed(out_value)), exp);
  endtask

  task automatic test_reset();
    rst = 1'b1; in_valid = 1'b0; in_code = '0;
    tbl_wr_en = 1'b0; tbl_wr_addr = '0; tbl_wr_data = '0;
    repeat (3) @(negedge clk);
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset in_ready", int'(in_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", int'(in_ready), 1);
    check("R1 quiet after reset", int'(out_valid), 0);
  endtask

  task automatic test_load();
    for (int i = 0; i < 17; i++) write_pt(i, i * 1000 - 8000);
  endtask

  task automatic test_grid_points();
    translate_one("R2 code 0", 12'h000);
    translate_one("R2 code 0x500", 12'h500);
    translate_one("R2 code 0xF00", 12'hF00);
  endtask

  task automatic test_interp();
    translate_one("R3 mid segment", 12'h280);
    translate_one("R3 low fraction", 12'h701);
    translate_one("R3 high fraction", 12'h3FF);
  endtask

  task automatic test_negative();
    write_pt(5, 30000);
    write_pt(6, -30000);
    translate_one("R8 steep descent mid", 12'h580);
    translate_one("R8 steep descent odd", 12'h533);
    translate_one("R8 negative base", 12'h1C7);
  endtask

  task automatic test_top_segment();
    write_pt(16, 12345);
    translate_one("R9 code 4095", 12'hFFF);
    translate_one("R9 top mid", 12'hF80);
  endtask

  task automatic test_stream();
    int codes [8] = '{12'h010, 12'h123, 12'hFFF, 12'h500, 12'h5FF, 12'h800, 12'hA5A, 12'h000};
    int exps [8];
    for (int k = 0; k < 8; k++) exps[k] = model(codes[k]);
    for (int j = 0; j < 10; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R5 stream valid", int'(out_valid), 1);
        check("R5 stream value", int'($signed(out_value)), exps[j-2]);
      end
      if (j < 8) begin in_valid = 1'b1; in_code = 12'(codes[j]); end
      else in_valid = 1'b0;
    end
  endtask

  task automatic test_collision();
    int e_old, e_new;
    e_old = tbl[3];
    @(negedge clk);
    tbl_wr_en = 1'b1; tbl_wr_addr = 5'd3; tbl_wr_data = 16'(-4321);
    in_valid = 1'b1; in_code = 12'h300;
    @(negedge clk);
    tbl_wr_en = 1'b0;
    tbl[3] = -4321;
    e_new = tbl[3];
    in_code = 12'h300;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 same-edge uses old", int'($signed(out_value)), e_old);
    @(negedge clk);
    check("R7 next-edge uses new", int'($signed(out_value)), e_new);
    translate_one("R6 written entry seen", 12'h240);
  endtask

  task automatic test_idle();
    in_valid = 1'b0;
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check("R4 idle no output", int'(out_valid), 0);
    end
  endtask

  initial begin
    #2000000;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    test_reset();
    test_load();
    test_grid_points();
    test_interp();
    test_negative();
    test_top_segment();
    test_stream();
    test_idle();
    test_collision();
    test_idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule